// File: doc/BRIEF.md
# Multidrop Address-Wake Serial Receiver

This block receives asynchronous serial characters and supports a nine-bit multidrop scheme for shared lines. In multidrop operation one extra bit follows the data bits and marks the character as an address (1) or as data (0). A slave station leaves its receiver disabled until an address arrives. While disabled it still watches the line, keeps only address-marked characters and throws data characters away. Local software reads the address, decides whether it matches, and drives `rx_en` high to take the data that follows.

Each accepted character goes into an 8-entry receive FIFO together with its status. The status is the address/data bit, which sits in the slot other modes use for parity error, plus a framing-error bit and a break bit. `rx_ready` is high while the FIFO holds anything. A sticky `overrun` output reports a character that arrived when the FIFO had no room. The line is oversampled through a 16x `baud_tick` enable. Baud generation, bus decoding and the address comparison are outside the block.

The receive state machine has six states:
- IDLE waits for a low sample (IDLE→START).
- START checks the line at half a bit. A high line goes back to IDLE (glitch). A low line goes to DATA.
- DATA samples each data bit at mid-bit. After the last one it goes to FLAG in multidrop mode, otherwise to STOP.
- FLAG samples the address/data bit (FLAG→STOP).
- STOP samples the stop bit and hands the character on. A high stop goes to IDLE. A low stop goes to HOLD.
- HOLD waits for the line to return high (HOLD→IDLE).

Top module: `mdrop_rx`

## Requirements
- R1: `par_mode` = 2'b11 selects multidrop, where one address/data bit follows the data bits. Any other value means no extra bit, and the stored flag is 0.
- R2: In multidrop mode with `rx_en` low, a character whose address/data bit is 1 is stored and `rx_ready` goes high.
- R3: In multidrop mode with `rx_en` low, a character whose address/data bit is 0 is discarded and the FIFO is left unchanged. Outside multidrop mode, a disabled receiver stores nothing.
- R4: With `rx_en` high, every received character is stored, whatever its address/data bit.
- R5: The FIFO head appears on the read outputs. `rd_data` holds the data right-aligned with the upper bits zero, and `rd_flag` holds the received address/data bit. `rd_pop` removes the head.
- R6: `char_len` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The data arrives LSB first after the start bit.
- R7: Every bit is sampled at mid-bit. A start bit counts only if the line is still low 8 ticks after the first low sample, so a shorter low pulse stores nothing.
- R8: The FIFO holds 8 entries. A character that must be stored while the FIFO is full is dropped and sets `overrun`. `overrun` stays high until the next `rd_pop`.
- R9: A stop bit sampled low sets `rd_frame_err` on the stored entry. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: A character whose data is all zero, whose address/data bit is zero and whose stop bit is low sets `rd_break` as well as `rd_frame_err`.
- R11: Framing, break and overrun reporting work the same whether `rx_en` is high or low.
- R12: After reset the FIFO is empty, and `rx_ready` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | Enable at 16x the bit rate |
| par_mode | input | 2 | Parity mode; 2'b11 selects multidrop |
| char_len | input | 2 | Data length code (5 to 8 bits) |
| rx_en | input | 1 | Receiver enable from local software |
| rd_pop | input | 1 | Removes the FIFO head |
| rx_ready | output | 1 | FIFO holds at least one entry |
| rd_data | output | 8 | Head entry data |
| rd_flag | output | 1 | Head entry address/data bit |
| rd_frame_err | output | 1 | Head entry framing error |
| rd_break | output | 1 | Head entry break |
| overrun | output | 1 | Sticky overrun, cleared by `rd_pop` |

## Verification
The bench uses the default parameters: 8-bit data, 16x oversampling and an 8-entry FIFO. It holds `baud_tick` high on every cycle, so one bit lasts 16 clocks. That makes a full character about 190 clocks long, short enough that nine back-to-back address characters fit in one run and reach the full-FIFO drop and the overrun flag. The short bit time also leaves room for every length code, both enable states in each mode, a framing error, a held-low break and a sub-half-bit glitch.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_FLAG,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    localparam logic [1:0] PM_MULTIDROP = 2'b11;

endpackage

// File: rtl/mdrx_fsm.sv
module mdrx_fsm
    import mdrx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              tick,
    input  logic              multidrop,
    input  logic [1:0]        char_len,
    output logic              frm_done,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_flag,
    output logic              frm_ferr,
    output logic              frm_brk
);
    localparam int CW      = $clog2(OVS);
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int MIN_LEN = DATA_W - 3;
    localparam logic [CW-1:0]    HALF = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0]    LAST = CW'(OVS - 1);
    localparam logic [BIT_W-1:0] TOPB = BIT_W'(DATA_W - 1);

    rx_state_t         state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [DATA_W-1:0] shf_q, shf_d;
    logic              flag_q, flag_d;
    logic              sync1_q, rx_s;
    logic [BIT_W-1:0]  len_m1;
    logic              done_c;

    assign len_m1 = BIT_W'(MIN_LEN - 1) + BIT_W'(char_len);

    // two-flop line synchroniser, idle high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            sync1_q <= rxd;
            rx_s    <= sync1_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shf_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
            shf_q   <= shf_d;
            flag_q  <= flag_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bit_d   = bit_q;
        shf_d   = shf_q;
        flag_d  = flag_q;
        done_c  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && !rx_s) begin
                    state_d = ST_START;
                    cnt_d   = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (cnt_q == HALF) begin
                        cnt_d = '0;
                        if (!rx_s) begin
                            state_d = ST_DATA;
                            bit_d   = '0;
                            shf_d   = '0;
                            flag_d  = 1'b0;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (cnt_q == LAST) begin
                        cnt_d = '0;
                        shf_d = {rx_s, shf_q[DATA_W-1:1]};
                        if (bit_q == len_m1) begin
                            state_d = multidrop ? ST_FLAG : ST_STOP;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FLAG: begin
                if (tick) begin
                    if (cnt_q == LAST) begin
                        cnt_d   = '0;
                        flag_d  = rx_s;
                        state_d = ST_STOP;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (cnt_q == LAST) begin
                        cnt_d   = '0;
                        done_c  = 1'b1;
                        state_d = rx_s ? ST_IDLE : ST_HOLD;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tick && rx_s) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frm_done = done_c;
        frm_data = shf_q >> (TOPB - len_m1);
        frm_flag = flag_q;
        frm_ferr = done_c && !rx_s;
        frm_brk  = done_c && !rx_s && !flag_q && (shf_q == '0);
    end

    p_start_glitch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && tick && cnt_q == HALF && rx_s) |=> (state_q == ST_IDLE));

    p_hold_after_bad_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && tick && cnt_q == LAST && !rx_s) |=> (state_q == ST_HOLD));

    p_flag_only_md_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLAG) |-> multidrop);

endmodule

// File: rtl/mdrx_accept.sv
module mdrx_accept (
    input  logic frm_done,
    input  logic multidrop,
    input  logic rx_en,
    input  logic frm_flag,
    input  logic fifo_full,
    output logic wr_req,
    output logic ovf_set
);
    logic keep;

    always_comb begin
        keep    = frm_done && (rx_en || (multidrop && frm_flag));
        wr_req  = keep && !fifo_full;
        ovf_set = keep && fifo_full;
    end

endmodule

// File: rtl/mdrx_fifo.sv
module mdrx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [W-1:0]               wdata,
    input  logic                       rd,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       full,
    output logic                       empty
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_rd;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign do_rd = rd && !empty;
    assign rdata = mem[rptr_q];
    assign cnt   = cnt_q;

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[wptr_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr) wptr_q <= wptr_q + 1'b1;
            if (do_rd) rptr_q <= rptr_q + 1'b1;
            unique case ({wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr);

    p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
    import mdrx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic [1:0]        par_mode,
    input  logic [1:0]        char_len,
    input  logic              rx_en,
    input  logic              rd_pop,
    output logic              rx_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              rd_frame_err,
    output logic              rd_break,
    output logic              overrun
);
    localparam int ENT_W = DATA_W + 3;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              multidrop;
    logic              frm_done, frm_flag, frm_ferr, frm_brk;
    logic [DATA_W-1:0] frm_data;
    logic              wr_req, ovf_set;
    logic [ENT_W-1:0]  head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full, fifo_empty;

    assign multidrop = (par_mode == PM_MULTIDROP);

    mdrx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .tick      (baud_tick),
        .multidrop (multidrop),
        .char_len  (char_len),
        .frm_done  (frm_done),
        .frm_data  (frm_data),
        .frm_flag  (frm_flag),
        .frm_ferr  (frm_ferr),
        .frm_brk   (frm_brk)
    );

    mdrx_accept u_acc (
        .frm_done  (frm_done),
        .multidrop (multidrop),
        .rx_en     (rx_en),
        .frm_flag  (frm_flag),
        .fifo_full (fifo_full),
        .wr_req    (wr_req),
        .ovf_set   (ovf_set)
    );

    mdrx_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_req),
        .wdata ({frm_ferr, frm_brk, frm_flag, frm_data}),
        .rd    (rd_pop),
        .rdata (head),
        .cnt   (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (ovf_set) begin
            overrun <= 1'b1;
        end else if (rd_pop) begin
            overrun <= 1'b0;
        end
    end

    assign rx_ready     = !fifo_empty;
    assign rd_data      = head[DATA_W-1:0];
    assign rd_flag      = head[DATA_W];
    assign rd_break     = head[DATA_W+1];
    assign rd_frame_err = head[DATA_W+2];

    p_keep_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && multidrop && !rx_en && frm_flag) |=> rx_ready);

    p_drop_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && multidrop && !rx_en && !frm_flag && !rd_pop)
        |=> (fifo_cnt == $past(fifo_cnt)));

    p_store_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_en && !fifo_full && !rd_pop)
        |=> (fifo_cnt == CNT_W'($past(fifo_cnt) + 1'b1)));

    p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_en && fifo_full) |=> overrun);

endmodule

// File: tb/mdrop_rx_bench.sv
module mdrop_rx_bench;
    localparam int CLK_P   = 10;
    localparam int BIT_CYC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b1;
    logic [1:0] par_mode = 2'b11;
    logic [1:0] char_len = 2'b11;
    logic       rx_en = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rx_ready, rd_flag, rd_frame_err, rd_break, overrun;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit settled = 1'b0;
    bit finished = 1'b0;
    logic [10:0] q[$];   // {ferr, brk, flag, data}
    bit ov_m = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mdrop_rx u_mdrop_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .par_mode(par_mode), .char_len(char_len), .rx_en(rx_en),
        .rd_pop(rd_pop), .rx_ready(rx_ready), .rd_data(rd_data),
        .rd_flag(rd_flag), .rd_frame_err(rd_frame_err),
        .rd_break(rd_break), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // per-clock comparison against the model while the line is quiet
    always @(posedge clk) begin
        #2;
        if (settled && rst_n && !finished) begin
            chk(rx_ready == (q.size() != 0), "R8", "ready vs model", rx_ready, q.size() != 0);
            chk(overrun == ov_m, "R8", "overrun vs model", overrun, ov_m);
        end
    end

    task automatic line_bit(input logic v);
        @(negedge clk);
        rxd = v;
        repeat (BIT_CYC - 1) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit flag, input bit stop,
                        input int low_extra);
        int len;
        bit md;
        logic [7:0] dm;
        settled = 1'b0;
        len = 5 + int'(char_len);
        md = (par_mode == 2'b11);
        line_bit(1'b0);
        for (int i = 0; i < len; i++) line_bit(d[i]);
        if (md) line_bit(flag);
        line_bit(stop);
        repeat (low_extra) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CYC) @(negedge clk);
        dm = d & 8'((1 << len) - 1);
        if (rx_en || (md && flag)) begin
            if (q.size() == 8) ov_m = 1'b1;
            else q.push_back({!stop, (!stop && dm == 0 && !(md && flag)),
                              md ? flag : 1'b0, dm});
        end
        settled = 1'b1;
    endtask

    task automatic pop(input string tag);
        @(negedge clk);
        chk(rx_ready == 1'b1, tag, "ready before pop", rx_ready, 1);
        if (q.size() != 0) begin
            chk({rd_frame_err, rd_break, rd_flag, rd_data} == q[0], tag, "head entry",
                {rd_frame_err, rd_break, rd_flag, rd_data}, q[0]);
            void'(q.pop_front());
        end
        ov_m = 1'b0;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(rx_ready == 1'b0, "R12", "ready after reset", rx_ready, 0);
        chk(overrun == 1'b0, "R12", "overrun after reset", overrun, 0);
        settled = 1'b1;

        // R3 disabled, data character discarded
        send(8'h3C, 1'b0, 1'b1, 0);
        chk(rx_ready == 1'b0, "R3", "data dropped while disabled", rx_ready, 0);
        // R2 disabled, address character kept; R5 flag in status slot
        send(8'hA5, 1'b1, 1'b1, 0);
        chk(rx_ready == 1'b1, "R2", "address stored", rx_ready, 1);
        pop("R5");

        // R4 enabled, both kinds stored
        rx_en = 1'b1;
        send(8'h5A, 1'b0, 1'b1, 0);
        send(8'h11, 1'b1, 1'b1, 0);
        pop("R4");
        pop("R4");

        // R6 lengths
        char_len = 2'b00;
        send(8'h15, 1'b1, 1'b1, 0);
        pop("R6");
        char_len = 2'b01;
        send(8'h2B, 1'b0, 1'b1, 0);
        pop("R6");
        char_len = 2'b10;
        send(8'h4E, 1'b1, 1'b1, 0);
        pop("R6");
        char_len = 2'b11;

        // R1 plain mode: no flag bit, flag stored as 0
        par_mode = 2'b00;
        send(8'h77, 1'b0, 1'b1, 0);
        pop("R1");
        rx_en = 1'b0;
        send(8'h12, 1'b0, 1'b1, 0);
        chk(rx_ready == 1'b0, "R1", "plain mode disabled drops", rx_ready, 0);
        par_mode = 2'b11;

        // R7 short low pulse ignored
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CYC) @(negedge clk);
        chk(rx_ready == 1'b0, "R7", "glitch ignored", rx_ready, 0);

        // R9 / R11 framing error while disabled on an address character
        send(8'h40, 1'b1, 1'b0, 0);
        pop("R9");
        pop_none_check("R11");

        // R10 break while enabled, line held low
        rx_en = 1'b1;
        send(8'h00, 1'b0, 1'b0, 5 * BIT_CYC);
        pop("R10");
        rx_en = 1'b0;

        // R8 overrun: nine address characters while disabled
        for (int i = 0; i < 9; i++) send(8'h80 + 8'(i), 1'b1, 1'b1, 0);
        chk(overrun == 1'b1, "R8", "overrun set on full", overrun, 1);
        for (int i = 0; i < 8; i++) pop("R8");
        @(negedge clk);
        chk(rx_ready == 1'b0, "R8", "ninth dropped, empty", rx_ready, 0);
        chk(overrun == 1'b0, "R8", "overrun cleared by pop", overrun, 0);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic pop_none_check(input string tag);
        @(negedge clk);
        chk(rx_ready == 1'b0, tag, "empty after error entry", rx_ready, 0);
    endtask

endmodule